// File: doc/BRIEF.md
# I2C bus status flag monitor

This block runs beside a byte-oriented I2C engine. It watches the SCL and SDA lines and keeps the status flags that software reads. There are four flags. The address flag reports that this node was addressed. The general-call flag reports a broadcast address byte. The last-bit flag holds the most recent sampled data line value. The arbitration flag reports that another master won the bus.

The block also supervises master operation. If this controller is driving a released (high) SDA as a master transmitter and sees the line held low, it has lost arbitration. It then forces its own master and transmit mode outputs low, which turns the controller into a slave receiver. It also raises a clock-stop output that tells the engine to stop clocking and to release both lines for the rest of the transfer.

Software clears the flags as a side effect of its normal register traffic: reading or writing the data buffer, or writing the control register. Byte shifting, clock generation and interrupt routing stay in the surrounding engine.

Top module: `i2c_flag_monitor`

## Requirements
- R1: After reset the four flags are low and the clock-stop output is 0. The mode outputs follow the mode inputs: mode_mst_o equals mode_mst_i and mode_trx_o equals mode_trx_i.
- R2: Bytes are sampled on SCL rising edges, most significant bit first, and the 9th rising edge is the acknowledge. In slave mode (mode_mst_o = 0) with free_fmt_i = 0, the first byte after a start condition sets addr_hit_o in two cases: its bits [7:1] equal slave_addr_i, or the whole byte is 0x00.
- R3: With free_fmt_i = 1, the first byte after a start condition sets addr_hit_o whatever its value.
- R4: A byte that is not the first one after a start condition never sets addr_hit_o.
- R5: A pulse on buf_rd_i or buf_wr_i clears addr_hit_o. A stop condition does not clear it.
- R6: gen_call_o sets when the first byte after a start condition is 0x00. A start condition (SDA falling while SCL is high) clears it, and so does a stop condition (SDA rising while SCL is high).
- R7: last_bit_o takes the SDA value at every SCL rising edge, so after each byte it holds the acknowledge bit.
- R8: Arbitration is lost when mode_mst_o = 1, mode_trx_o = 1, sda_drv_i = 1 and SDA is sampled low at an SCL rising edge. On loss, arb_lost_o sets, and mode_mst_o and mode_trx_o are forced to 0 until the next ctl_wr_i pulse.
- R9: clk_stop_o sets on arbitration loss and stays set until a stop condition.
- R10: A pulse on buf_rd_i, buf_wr_i or ctl_wr_i clears arb_lost_o.
- R11: If a clearing strobe and a set event fall in the same cycle, the flag sets.
- R12: The lines pass through a two-flop synchronizer. A flag changes on the third clock edge after the line change that causes it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | SCL line level, asynchronous |
| sda_i | input | 1 | SDA line level, asynchronous |
| sda_drv_i | input | 1 | SDA level this controller drives (1 = released) |
| slave_addr_i | input | 7 | Programmed slave address |
| free_fmt_i | input | 1 | 1 = free data format, no address compare |
| mode_mst_i | input | 1 | Master mode bit from the control register |
| mode_trx_i | input | 1 | Transmit mode bit from the control register |
| buf_rd_i | input | 1 | Data buffer read strobe |
| buf_wr_i | input | 1 | Data buffer write strobe |
| ctl_wr_i | input | 1 | Control register write strobe |
| addr_hit_o | output | 1 | Addressed as slave |
| gen_call_o | output | 1 | General-call address received |
| last_bit_o | output | 1 | SDA value at the last SCL rising edge |
| arb_lost_o | output | 1 | Arbitration lost |
| mode_mst_o | output | 1 | Effective master mode bit |
| mode_trx_o | output | 1 | Effective transmit mode bit |
| clk_stop_o | output | 1 | Stop clock output and release both lines |

## Verification
Two functions can fall in the same cycle: a flag's set event and the register access that clears it. The bench provokes this twice. It fires a buffer read in the exact cycle the eighth bit of a matching address byte is sampled. It fires a control write in the cycle an SCL rising edge finds SDA pulled low against a released master. To hit those cycles, the strobe is placed two clock falls after the SCL rise, which accounts for the synchronizer delay. Both cases pass only if the flag reads set afterwards and the mode outputs stay demoted.

// File: rtl/i2c_mon_pkg.sv
package i2c_mon_pkg;
  localparam int unsigned ADDR_W = 7;
  localparam int unsigned BYTE_W = ADDR_W + 1;
  localparam int unsigned CNT_W  = $clog2(BYTE_W + 1);

  typedef struct packed {
    logic start;
    logic stop;
    logic scl_rise;
    logic sda;
  } bus_evt_t;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync
  import i2c_mon_pkg::*;
#(
  parameter int unsigned STAGES = 2
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     scl_i,
  input  logic     sda_i,
  output bus_evt_t evt_o
);
  // [1] = scl, [0] = sda; lines idle high
  logic [1:0] stg_q [STAGES];
  logic [1:0] prev_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg_q[g] <= 2'b11;
        else         stg_q[g] <= {scl_i, sda_i};
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg_q[g] <= 2'b11;
        else         stg_q[g] <= stg_q[g-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) prev_q <= 2'b11;
    else         prev_q <= stg_q[STAGES-1];

  logic scl_s, sda_s;
  assign scl_s = stg_q[STAGES-1][1];
  assign sda_s = stg_q[STAGES-1][0];

  assign evt_o.sda      = sda_s;
  assign evt_o.scl_rise = scl_s & ~prev_q[1];
  assign evt_o.start    = scl_s & prev_q[1] & prev_q[0] & ~sda_s;
  assign evt_o.stop     = scl_s & prev_q[1] & ~prev_q[0] & sda_s;

  // R6
  start_stop_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(evt_o.start && evt_o.stop));
endmodule

// File: rtl/i2c_byte_track.sv
module i2c_byte_track
  import i2c_mon_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  bus_evt_t          evt_i,
  output logic              byte_done_o,
  output logic              first_byte_o,
  output logic [BYTE_W-1:0] rx_byte_o
);
  logic [CNT_W-1:0]  cnt_q;
  logic [BYTE_W-1:0] sh_q;
  logic              first_q;

  assign byte_done_o  = evt_i.scl_rise && (cnt_q == CNT_W'(BYTE_W - 1));
  assign rx_byte_o    = {sh_q[BYTE_W-2:0], evt_i.sda};
  assign first_byte_o = first_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      sh_q    <= '0;
      first_q <= 1'b0;
    end else if (evt_i.start) begin
      cnt_q   <= '0;
      first_q <= 1'b1;
    end else if (evt_i.stop) begin
      cnt_q   <= '0;
      first_q <= 1'b0;
    end else if (evt_i.scl_rise) begin
      // 9th edge is the acknowledge slot
      if (cnt_q == CNT_W'(BYTE_W)) cnt_q <= '0;
      else                          cnt_q <= cnt_q + 1'b1;
      if (cnt_q < CNT_W'(BYTE_W))  sh_q  <= rx_byte_o;
      if (byte_done_o)              first_q <= 1'b0;
    end
  end

  // R2
  bit_cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(BYTE_W));
  // R4
  first_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_done_o && !evt_i.start) |=> !first_q);
endmodule

// File: rtl/i2c_flag_regs.sv
module i2c_flag_regs
  import i2c_mon_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  bus_evt_t          evt_i,
  input  logic              byte_done_i,
  input  logic              first_byte_i,
  input  logic [BYTE_W-1:0] rx_byte_i,
  input  logic [ADDR_W-1:0] slave_addr_i,
  input  logic              free_fmt_i,
  input  logic              mode_mst_i,
  input  logic              mode_trx_i,
  input  logic              sda_drv_i,
  input  logic              buf_rd_i,
  input  logic              buf_wr_i,
  input  logic              ctl_wr_i,
  output logic              addr_hit_o,
  output logic              gen_call_o,
  output logic              last_bit_o,
  output logic              arb_lost_o,
  output logic              mode_mst_o,
  output logic              mode_trx_o,
  output logic              clk_stop_o
);
  logic addr_q, gc_q, lb_q, al_q, demote_q, stop_q;
  logic slave_byte, zero_byte, addr_eq, addr_set, gc_set, arb_evt, buf_acc;

  assign mode_mst_o = mode_mst_i & ~demote_q;
  assign mode_trx_o = mode_trx_i & ~demote_q;

  assign slave_byte = byte_done_i & first_byte_i & ~mode_mst_o;
  assign zero_byte  = (rx_byte_i == '0);
  assign addr_eq    = (rx_byte_i[BYTE_W-1:1] == slave_addr_i);
  assign addr_set   = slave_byte & (free_fmt_i | addr_eq | zero_byte);
  assign gc_set     = slave_byte & zero_byte;
  assign arb_evt    = mode_mst_o & mode_trx_o & sda_drv_i & evt_i.scl_rise & ~evt_i.sda;
  assign buf_acc    = buf_rd_i | buf_wr_i;

  // set wins over clear throughout
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q   <= 1'b0;
      gc_q     <= 1'b0;
      lb_q     <= 1'b0;
      al_q     <= 1'b0;
      demote_q <= 1'b0;
      stop_q   <= 1'b0;
    end else begin
      if (addr_set)                          addr_q <= 1'b1;
      else if (buf_acc)                      addr_q <= 1'b0;

      if (gc_set)                            gc_q <= 1'b1;
      else if (evt_i.start || evt_i.stop)    gc_q <= 1'b0;

      if (evt_i.scl_rise)                    lb_q <= evt_i.sda;

      if (arb_evt)                           al_q <= 1'b1;
      else if (buf_acc || ctl_wr_i)          al_q <= 1'b0;

      if (arb_evt)                           demote_q <= 1'b1;
      else if (ctl_wr_i)                     demote_q <= 1'b0;

      if (arb_evt)                           stop_q <= 1'b1;
      else if (evt_i.stop)                   stop_q <= 1'b0;
    end
  end

  assign addr_hit_o = addr_q;
  assign gen_call_o = gc_q;
  assign last_bit_o = lb_q;
  assign arb_lost_o = al_q;
  assign clk_stop_o = stop_q;

  // R4
  addr_only_on_byte_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!byte_done_i && !addr_q) |=> !addr_q);
  // R5
  addr_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (buf_acc && !byte_done_i) |=> !addr_q);
  // R6
  gc_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i.start || evt_i.stop) |=> !gc_q);
  // R7
  last_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_i.scl_rise |=> (lb_q == $past(evt_i.sda)));
  // R8
  arb_demote_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arb_evt |=> (al_q && !mode_mst_o && !mode_trx_o && stop_q));
  // R10
  arb_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!arb_evt && (buf_acc || ctl_wr_i)) |=> !al_q);
endmodule

// File: rtl/i2c_flag_monitor.sv
module i2c_flag_monitor
  import i2c_mon_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              sda_drv_i,
  input  logic [ADDR_W-1:0] slave_addr_i,
  input  logic              free_fmt_i,
  input  logic              mode_mst_i,
  input  logic              mode_trx_i,
  input  logic              buf_rd_i,
  input  logic              buf_wr_i,
  input  logic              ctl_wr_i,
  output logic              addr_hit_o,
  output logic              gen_call_o,
  output logic              last_bit_o,
  output logic              arb_lost_o,
  output logic              mode_mst_o,
  output logic              mode_trx_o,
  output logic              clk_stop_o
);
  bus_evt_t          evt;
  logic              byte_done, first_byte;
  logic [BYTE_W-1:0] rx_byte;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i, .evt_o(evt)
  );

  i2c_byte_track u_track (
    .clk_i, .rst_ni, .evt_i(evt),
    .byte_done_o(byte_done), .first_byte_o(first_byte), .rx_byte_o(rx_byte)
  );

  i2c_flag_regs u_flags (
    .clk_i, .rst_ni, .evt_i(evt),
    .byte_done_i(byte_done), .first_byte_i(first_byte), .rx_byte_i(rx_byte),
    .slave_addr_i, .free_fmt_i, .mode_mst_i, .mode_trx_i, .sda_drv_i,
    .buf_rd_i, .buf_wr_i, .ctl_wr_i,
    .addr_hit_o, .gen_call_o, .last_bit_o, .arb_lost_o,
    .mode_mst_o, .mode_trx_o, .clk_stop_o
  );

  // R9
  clk_stop_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clk_stop_o && !evt.stop) |=> clk_stop_o);
endmodule

// File: tb/i2c_flag_monitor_tb_top.sv
module i2c_flag_monitor_tb_top;
  localparam time CLK_PERIOD = 10ns;
  localparam int  MAX_CYCLES = 200000;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic scl = 1'b1, sda = 1'b1, sda_drv = 1'b0;
  logic [6:0] slave_addr = 7'h2A;
  logic free_fmt = 1'b0, mst = 1'b0, trx = 1'b0;
  logic buf_rd = 1'b0, buf_wr = 1'b0, ctl_wr = 1'b0;
  logic addr_hit, gen_call, last_bit, arb_lost, mst_o, trx_o, clk_stop;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_flag_monitor dut_i (
    .clk_i(clk), .rst_ni, .scl_i(scl), .sda_i(sda), .sda_drv_i(sda_drv),
    .slave_addr_i(slave_addr), .free_fmt_i(free_fmt), .mode_mst_i(mst), .mode_trx_i(trx),
    .buf_rd_i(buf_rd), .buf_wr_i(buf_wr), .ctl_wr_i(ctl_wr),
    .addr_hit_o(addr_hit), .gen_call_o(gen_call), .last_bit_o(last_bit),
    .arb_lost_o(arb_lost), .mode_mst_o(mst_o), .mode_trx_o(trx_o), .clk_stop_o(clk_stop)
  );

  // observed vector order: {addr_hit, gen_call, last_bit, arb_lost, mst_o, trx_o, clk_stop}
  typedef struct {
    string      tag;
    logic [6:0] exp;
    logic [6:0] mask;
  } item_t;

  item_t exp_q[$];
  int    pending = 0;
  int    n_checks = 0, n_errors = 0;
  bit    done = 1'b0;

  // monitor: pops expected items and compares against the outputs
  initial begin
    forever begin
      wait (pending != 0);
      @(negedge clk);
      begin
        item_t it;
        logic [6:0] obs;
        it  = exp_q.pop_front();
        obs = {addr_hit, gen_call, last_bit, arb_lost, mst_o, trx_o, clk_stop};
        n_checks++;
        if (((obs ^ it.exp) & it.mask) != 7'b0) begin
          n_errors++;
          $display("FAIL %s: actual %b expected %b (mask %b)", it.tag, obs, it.exp, it.mask);
        end
      end
      pending--;
    end
  end

  task automatic expect_out(string tag, logic [6:0] exp, logic [6:0] mask);
    item_t it;
    it.tag = tag; it.exp = exp; it.mask = mask;
    exp_q.push_back(it);
    pending++;
    wait (pending == 0);
  endtask

  task automatic hold(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda = 1'b1; hold(4);
    scl = 1'b1; hold(4);
    sda = 1'b0; hold(4);
    scl = 1'b0; hold(4);
  endtask

  task automatic bus_stop();
    sda = 1'b0; hold(4);
    scl = 1'b1; hold(4);
    sda = 1'b1; hold(4);
  endtask

  // strb: 0 none, 1 buf_rd, 2 ctl_wr, pulsed in the cycle the SCL rise is seen
  task automatic send_bit(logic b, int strb);
    sda = b; hold(4);
    scl = 1'b1;
    hold(2);
    if (strb == 1) buf_rd = 1'b1;
    if (strb == 2) ctl_wr = 1'b1;
    hold(1);
    buf_rd = 1'b0; ctl_wr = 1'b0;
    hold(2);
    scl = 1'b0; hold(4);
  endtask

  task automatic send_byte(logic [7:0] b, logic ack, int last_strb);
    for (int i = 7; i >= 0; i--) send_bit(b[i], (i == 0) ? last_strb : 0);
    send_bit(ack, 0);
  endtask

  task automatic pulse_rd(); buf_rd = 1'b1; hold(1); buf_rd = 1'b0; hold(3); endtask
  task automatic pulse_wr(); buf_wr = 1'b1; hold(1); buf_wr = 1'b0; hold(3); endtask
  task automatic pulse_ctl(); ctl_wr = 1'b1; hold(1); ctl_wr = 1'b0; hold(3); endtask

  initial begin
    hold(3);
    rst_ni = 1'b1;
    hold(2);
    // R1 reset state
    expect_out("R1 reset", 7'b0000000, 7'b1111111);

    // R2 address match, R7 ack captured, R12 after sync
    bus_start();
    send_byte(8'h54, 1'b0, 0);
    expect_out("R2 R7 R12 address match", 7'b1000000, 7'b1111000);
    pulse_rd();
    expect_out("R5 buffer read clears", 7'b0000000, 7'b1000000);
    send_byte(8'h54, 1'b1, 0);
    expect_out("R4 R7 second byte ignored", 7'b0010000, 7'b1010000);

    // R6 general call
    bus_stop();
    bus_start();
    send_byte(8'h00, 1'b0, 0);
    expect_out("R6 R2 general call", 7'b1100000, 7'b1100000);
    bus_stop();
    expect_out("R6 R5 stop clears gcall only", 7'b1000000, 7'b1100000);
    pulse_wr();
    expect_out("R5 buffer write clears", 7'b0000000, 7'b1000000);

    bus_start();
    send_byte(8'h30, 1'b0, 0);
    expect_out("R2 mismatch", 7'b0000000, 7'b1100000);
    bus_start();
    send_byte(8'h00, 1'b0, 0);
    bus_start();
    expect_out("R6 repeated start clears gcall", 7'b1000000, 7'b1100000);
    pulse_rd();
    bus_stop();

    // R3 free data format
    free_fmt = 1'b1;
    bus_start();
    send_byte(8'h77, 1'b0, 0);
    expect_out("R3 free format first byte", 7'b1000000, 7'b1100000);
    pulse_wr();
    free_fmt = 1'b0;
    bus_stop();

    // R11 set beats buffer read on the same cycle
    bus_start();
    send_byte(8'h54, 1'b0, 1);
    expect_out("R11 address set over read", 7'b1000000, 7'b1000000);
    pulse_rd();
    bus_stop();

    // R8 arbitration loss
    mst = 1'b1; trx = 1'b1;
    expect_out("R1 mode pass-through", 7'b0000110, 7'b0000110);
    sda_drv = 1'b1;
    bus_start();
    send_bit(1'b0, 0);
    expect_out("R8 R9 arbitration lost", 7'b0001001, 7'b0011111);
    pulse_rd();
    expect_out("R10 read clears arb", 7'b0000001, 7'b0001111);
    bus_stop();
    expect_out("R9 stop clears clk_stop", 7'b0000000, 7'b0000111);
    pulse_ctl();
    expect_out("R8 control write restores mode", 7'b0000110, 7'b0001110);

    // R11 arbitration set over control write
    bus_start();
    send_bit(1'b0, 2);
    expect_out("R11 arb set over ctl write", 7'b0001001, 7'b0001111);
    pulse_wr();
    expect_out("R10 write clears arb", 7'b0000000, 7'b0001000);
    bus_start();
    send_bit(1'b1, 0);
    mst = 1'b0; trx = 1'b0; sda_drv = 1'b0;
    expect_out("R8 no loss when line high", 7'b0000000, 7'b0001000);
    mst = 1'b1; trx = 1'b1; sda_drv = 1'b1;
    send_bit(1'b0, 0);
    mst = 1'b0; trx = 1'b0; sda_drv = 1'b0;
    pulse_ctl();
    expect_out("R10 control write clears arb", 7'b0000000, 7'b0001110);
    bus_stop();

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (MAX_CYCLES) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end
endmodule